// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a clocked retriggerable one-shot. Three asynchronous control inputs feed it: an active-low gate (`gate_n`), an active-high gate (`gate_p`) and an active-low clear (`clear_n`). When the gates reach their qualifying combination through an edge on one of the three inputs, the block drives a pulse of a programmed number of clock cycles on `pulse`. Its exact complement appears on `pulse_n`.

A new qualifying edge during a pulse reloads the full count. Repeated edges can therefore hold the output high without a gap. Pulling the clear low ends a pulse early and blocks new triggers for as long as it stays low.

Each input passes through a synchroniser of `SYNC_STAGES` flops before edge detection. Only the sampled level crossing matters, not the slew of the edge. Input levels that are already present when reset is released are not treated as edges. With the default two stages, a pulse begins on the third rising clock edge after the input changes.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst` is high, `pulse` is 0 and `pulse_n` is 1. After release, no pulse starts from input levels that were already stable during reset.
- R2: `pulse_n` is the complement of `pulse` in every cycle.
- R3: A 0-to-1 change of `gate_p` while `gate_n` is 0 and `clear_n` is 1 starts a pulse.
- R4: A 1-to-0 change of `gate_n` while `gate_p` is 1 and `clear_n` is 1 starts a pulse.
- R5: A 0-to-1 change of `clear_n` while `gate_n` is 0 and `gate_p` is 1 in the same sampled cycle starts a pulse.
- R6: With `width` = N > 0, `pulse` is high for exactly N consecutive cycles. With the default two synchroniser stages, it rises on the third rising clock edge after the triggering input change.
- R7: A trigger taken while `width` is 0 produces no pulse.
- R8: A qualifying trigger during a pulse reloads the full count N. The output stays high without a gap until N cycles after the latest trigger.
- R9: When `clear_n` falls, an active pulse ends on the third rising edge after the change, which cuts the pulse short.
- R10: While `clear_n` is low, edges on `gate_n` and `gate_p` start no pulse, including after `clear_n` returns high.
- R11: Edges that do not qualify start no pulse. These are a rise of `gate_p` with `gate_n` high, a fall of `gate_n` with `gate_p` low, and a rise of `clear_n` with either gate inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_n | input | 1 | Active-low trigger gate, asynchronous |
| gate_p | input | 1 | Active-high trigger gate, asynchronous |
| clear_n | input | 1 | Active-low clear, asynchronous; its rising edge can also trigger |
| width | input | CNT_W | Pulse length in clock cycles, sampled when a trigger is taken |
| pulse | output | 1 | One-shot output, active high |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The assertions check the cycle-level rules on every cycle:
- the complement relation between the two outputs;
- that a low clear suppresses the trigger and empties the counter on the next edge;
- that a taken trigger loads the full count, or yields no pulse when the width is zero;
- that the counter steps down by one otherwise.

Some behaviour can only be shown by the bench's scenarios, which observe the pins over whole pulses. These are:
- the end-to-end latency through the synchronisers;
- the exact pulse length for each of the three trigger modes;
- the gap-free merging of retriggered pulses;
- the rejection of non-qualifying edges;
- the absence of a pulse after reset release.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    localparam int DEF_CNT_W       = 16;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int NUM_CTRL        = 3;

    // Bit positions of the control inputs inside the synchroniser vector
    localparam int IDX_GN  = 0;
    localparam int IDX_GP  = 1;
    localparam int IDX_CLR = 2;

    // Idle (non-triggering) levels used at reset
    localparam logic [NUM_CTRL-1:0] CTRL_IDLE = 3'b101;

    typedef struct packed {
        logic clr_n;
        logic gp;
        logic gn;
    } ctrl_lv_t;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_GP   = 2'd1,
        TRIG_GN   = 2'd2,
        TRIG_CLR  = 2'd3
    } trig_src_e;

    function automatic ctrl_lv_t to_ctrl(input logic [NUM_CTRL-1:0] v);
        ctrl_lv_t c;
        c.gn    = v[IDX_GN];
        c.gp    = v[IDX_GP];
        c.clr_n = v[IDX_CLR];
        return c;
    endfunction

    function automatic logic gates_open(input ctrl_lv_t c);
        return (!c.gn) && c.gp;
    endfunction

endpackage

// File: rtl/os_input_sync.sv
module os_input_sync
    import oneshot_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES,
    parameter int NIN    = NUM_CTRL,
    parameter logic [NIN-1:0] IDLE = CTRL_IDLE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NIN-1:0] raw,
    output logic [NIN-1:0] cur,
    output logic [NIN-1:0] prv,
    output logic           valid
);
    localparam int VLD_W = STAGES + 1;

    logic [VLD_W-1:0] vld_sh;

    for (genvar i = 0; i < NIN; i++) begin : g_chan
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{IDLE[i]}};
                last  <= IDLE[i];
            end else begin
                if (STAGES > 1) begin
                    chain <= {chain[STAGES-2:0], raw[i]};
                end else begin
                    chain <= raw[i];
                end
                last <= chain[STAGES-1];
            end
        end
        assign cur[i] = chain[STAGES-1];
        assign prv[i] = last;
    end

    // Edges count only once the chain and history hold real samples
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sh <= '0;
        end else begin
            vld_sh <= {vld_sh[VLD_W-2:0], 1'b1};
        end
    end
    assign valid = vld_sh[VLD_W-1];

    AST_VALID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid); // R1

endmodule

// File: rtl/os_trigger_qual.sv
module os_trigger_qual
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctrl_lv_t  cur,
    input  ctrl_lv_t  prv,
    input  logic      valid,
    output trig_src_e src
);
    logic gp_rise, gn_fall, clr_rise;

    assign gp_rise  = cur.gp && !prv.gp;
    assign gn_fall  = !cur.gn && prv.gn;
    assign clr_rise = cur.clr_n && !prv.clr_n;

    always_comb begin
        src = TRIG_NONE;
        if (valid && gates_open(cur)) begin
            if (clr_rise) begin
                src = TRIG_CLR;
            end else if (cur.clr_n && gp_rise) begin
                src = TRIG_GP;
            end else if (cur.clr_n && gn_fall) begin
                src = TRIG_GN;
            end
        end
    end

    AST_NO_TRIG_WHILE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !cur.clr_n |-> src == TRIG_NONE); // R10

    AST_NO_TRIG_GATES_SHUT: assert property (@(posedge clk) disable iff (rst)
        (cur.gn || !cur.gp) |-> src == TRIG_NONE); // R11

    AST_QUIET_UNTIL_VALID: assert property (@(posedge clk) disable iff (rst)
        !valid |-> src == TRIG_NONE); // R1

endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_ok,
    input  trig_src_e        src,
    input  logic [CNT_W-1:0] width,
    output logic             q,
    output logic             q_n
);
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             fire;

    assign fire = (src != TRIG_NONE);

    always_comb begin
        cnt_nxt = cnt;
        if (!clr_ok) begin
            cnt_nxt = '0;
        end else if (fire) begin
            cnt_nxt = width;
        end else if (cnt != '0) begin
            cnt_nxt = cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            q   <= 1'b0;
            q_n <= 1'b1;
        end else begin
            cnt <= cnt_nxt;
            q   <= (cnt_nxt != '0);
            q_n <= (cnt_nxt == '0);
        end
    end

    AST_OUTPUTS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        q_n == !q); // R2

    AST_CLEAR_KILLS: assert property (@(posedge clk) disable iff (rst)
        !clr_ok |=> !q); // R9

    AST_FULL_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (fire && clr_ok && width != '0) |=> (q && cnt == $past(width))); // R8

    AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (fire && width == '0) |=> !q); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && !fire && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R6

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_n,
    input  logic             gate_p,
    input  logic             clear_n,
    input  logic [CNT_W-1:0] width,
    output logic             pulse,
    output logic             pulse_n
);
    logic [NUM_CTRL-1:0] raw_v, cur_v, prv_v;
    logic                lv_valid;
    ctrl_lv_t            cur_c, prv_c;
    trig_src_e           src;

    always_comb begin
        raw_v          = '0;
        raw_v[IDX_GN]  = gate_n;
        raw_v[IDX_GP]  = gate_p;
        raw_v[IDX_CLR] = clear_n;
    end

    os_input_sync #(
        .STAGES (SYNC_STAGES),
        .NIN    (NUM_CTRL),
        .IDLE   (CTRL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_v),
        .cur   (cur_v),
        .prv   (prv_v),
        .valid (lv_valid)
    );

    assign cur_c = to_ctrl(cur_v);
    assign prv_c = to_ctrl(prv_v);

    os_trigger_qual u_qual (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur_c),
        .prv   (prv_c),
        .valid (lv_valid),
        .src   (src)
    );

    os_pulse_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_ok (cur_c.clr_n),
        .src    (src),
        .width  (width),
        .q      (pulse),
        .q_n    (pulse_n)
    );

endmodule

// File: tb/sim_retrig_oneshot.sv
module sim_retrig_oneshot;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             gate_n, gate_p, clear_n;
    logic [CNT_W-1:0] width;
    logic             pulse, pulse_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    retrig_oneshot #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .gate_n(gate_n), .gate_p(gate_p),
        .clear_n(clear_n), .width(width), .pulse(pulse), .pulse_n(pulse_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called right after driving at a negedge; samples the next span negedges
    task automatic measure(input int span, output int first, output int last,
                           output int cnt, output int cmpl_bad);
        first = -1; last = -1; cnt = 0; cmpl_bad = 0;
        for (int i = 1; i <= span; i++) begin
            @(negedge clk);
            if (pulse_n !== ~pulse) cmpl_bad++;
            if (pulse) begin
                cnt++;
                if (first < 0) first = i;
                last = i;
            end
        end
    endtask

    task automatic t_reset();
        int hi = 0;
        rst = 1; gate_n = 0; gate_p = 1; clear_n = 1; width = 5;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 2) begin gate_p = 0; end
            if (i == 3) begin gate_p = 1; end
            if (pulse !== 1'b0 || pulse_n !== 1'b1) hi++;
        end
        chk(hi == 0, "R1 outputs idle during reset", hi, 0);
        rst = 0;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pulse) hi++;
        end
        chk(hi == 0, "R1 no pulse after reset release", hi, 0);
    endtask

    task automatic t_mode_gp(input int w);
        int f, l, c, b;
        gate_n = 0; gate_p = 0; clear_n = 1; width = CNT_W'(w);
        idle(w + 8);
        gate_p = 1;
        measure(w + 10, f, l, c, b);
        chk(f == 3, "R3 gate_p rise start cycle", f, 3);
        chk(c == w && l == f + w - 1, "R6 pulse length (gate_p)", c, w);
        chk(b == 0, "R2 complement during gate_p pulse", b, 0);
    endtask

    task automatic t_mode_gn(input int w);
        int f, l, c, b;
        gate_n = 1; gate_p = 1; clear_n = 1; width = CNT_W'(w);
        idle(w + 8);
        gate_n = 0;
        measure(w + 10, f, l, c, b);
        chk(f == 3, "R4 gate_n fall start cycle", f, 3);
        chk(c == w, "R6 pulse length (gate_n)", c, w);
        chk(b == 0, "R2 complement during gate_n pulse", b, 0);
    endtask

    task automatic t_mode_clr(input int w);
        int f, l, c, b;
        gate_n = 0; gate_p = 1; clear_n = 0; width = CNT_W'(w);
        idle(w + 8);
        clear_n = 1;
        measure(w + 10, f, l, c, b);
        chk(f == 3, "R5 clear rise start cycle", f, 3);
        chk(c == w, "R6 pulse length (clear rise)", c, w);
    endtask

    task automatic t_width_zero();
        int f, l, c, b;
        gate_n = 0; gate_p = 0; clear_n = 1; width = 0;
        idle(8);
        gate_p = 1;
        measure(12, f, l, c, b);
        chk(c == 0, "R7 zero width gives no pulse", c, 0);
    endtask

    task automatic t_retrig();
        int first = -1, last = -1, cnt = 0;
        gate_n = 0; gate_p = 0; clear_n = 1; width = 10;
        idle(20);
        gate_p = 1;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (pulse) begin
                cnt++;
                if (first < 0) first = i;
                last = i;
            end
            if (i == 3) gate_p = 0;
            if (i == 6) gate_p = 1;
        end
        chk(first == 3 && last == 18, "R8 retrigger extends to full width", last, 18);
        chk(cnt == 16, "R8 no gap in retriggered pulse", cnt, 16);
    endtask

    task automatic t_clear_trunc();
        int first = -1, last = -1, cnt = 0;
        gate_n = 0; gate_p = 0; clear_n = 1; width = 20;
        idle(25);
        gate_p = 1;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (pulse) begin
                cnt++;
                if (first < 0) first = i;
                last = i;
            end
            if (i == 5)  clear_n = 0;
            if (i == 10) gate_p = 0;
            if (i == 13) gate_p = 1;
            if (i == 16) gate_p = 0;
            if (i == 20) begin gate_n = 1; end
            if (i == 23) begin gate_p = 1; gate_n = 0; end
        end
        chk(first == 3 && last == 7, "R9 clear ends pulse early", last, 7);
        chk(cnt == 5, "R10 gate edges ignored while clear low", cnt, 5);
        // clear returns high with gate_p low: not a trigger
        gate_p = 0;
        idle(3);
        clear_n = 1;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pulse) cnt++;
        end
        chk(cnt == 0, "R10 no late pulse after clear release", cnt, 0);
    endtask

    task automatic t_nonqual();
        int f, l, c, b;
        width = 6;
        gate_n = 1; gate_p = 0; clear_n = 1;
        idle(10);
        gate_p = 1;
        measure(10, f, l, c, b);
        chk(c == 0, "R11 gate_p rise with gate_n high", c, 0);
        gate_n = 1; gate_p = 0;
        idle(6);
        gate_n = 0;
        measure(10, f, l, c, b);
        chk(c == 0, "R11 gate_n fall with gate_p low", c, 0);
        gate_n = 1; gate_p = 1; clear_n = 0;
        idle(6);
        clear_n = 1;
        measure(10, f, l, c, b);
        chk(c == 0, "R11 clear rise with gate_n high", c, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mode_gp(7);
        t_mode_gp(1);
        t_mode_gn(12);
        t_mode_clr(4);
        t_width_zero();
        t_retrig();
        t_clear_trunc();
        t_nonqual();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule